// File: doc/BRIEF.md
# ESF Bit-Oriented Message Transmitter

This block produces the serial bit stream for the data link of an extended-superframe T1 line when a bit-oriented message has to be sent. A 6-bit message code is turned into a 16-bit codeword. The codeword has a run of eight ones, then a zero, then the six code bits, then a closing zero. While the send control is high, the codewords go out back to back, one bit on each cycle where the transmit bit enable is asserted.

When no message is being sent, the line carries either constant ones or the other link traffic presented on a pass-through input, depending on a select input. The block also counts how many complete codewords went out during the current send request, and it raises a flag once the minimum of ten repetitions has been reached. Software holds the send control high until it sees that flag.

Top module: `bom_tx`

## Requirements
- R1: While rst_n is low at a clock edge, dl_out becomes 1, rep_count becomes 0 and rep_done becomes 0.
- R2: A codeword is emitted in position order 0 to 15. Positions 0 to 7 are 1. Position 8 is 0. Positions 9 to 14 carry code[0] to code[5], in that order. Position 15 is 0.
- R3: A codeword starts on the first bit_en cycle with send high when no codeword is in progress. While send stays high, the next codeword starts on the bit_en that follows the position-15 bit, with no gap.
- R4: code is sampled on the bit_en that emits position 0. Changes to code later in the same codeword only affect the following codeword.
- R5: If send falls while a codeword is in progress, the remaining positions of that codeword are still emitted before the idle source is used.
- R6: On a bit_en with no codeword in progress and send low, dl_out becomes 1 when pass_sel is 0, and becomes link_in when pass_sel is 1.
- R7: dl_out changes only at clock edges where bit_en is high. Otherwise it holds its value.
- R8: rep_count increases by one at each edge where the position-15 bit is emitted and send is high. It saturates at 15.
- R9: rep_count becomes 0 at any clock edge where send is low. This includes an edge that emits a position-15 bit.
- R10: rep_done is 1 exactly when rep_count is 10 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Transmit bit enable, one line bit per high cycle |
| send | input | 1 | Request to transmit the message codeword repeatedly |
| code | input | 6 | Message code, bit 0 sent first |
| pass_sel | input | 1 | Idle source: 0 selects ones, 1 selects link_in |
| link_in | input | 1 | Other data-link traffic passed through when idle |
| dl_out | output | 1 | Serial data-link output bit |
| rep_count | output | 4 | Complete codewords sent in the current request, saturating |
| rep_done | output | 1 | Minimum repetition count reached |

## Verification
Two functions of the repetition counter can fall on the same clock edge: counting a finished codeword and clearing because send is low. The bench provokes this by lowering send exactly on the bit_en that carries the position-15 bit of a codeword. The judgement is that rep_count reads 0 afterwards, and that the following bit comes from the idle source rather than a new prefix. A second overlap happens when code changes on the very bit_en that starts a codeword. There the new value must appear in positions 9 to 14 of that codeword.

// File: rtl/bom_pkg.sv
// Package: shared default dimensions for the bit-oriented message transmitter.
// Assumes: the codeword is prefix ones, a zero, the code bits, and a closing zero.
package bom_pkg;
    localparam int BOM_PREFIX_ONES = 8;
    localparam int BOM_CODE_W      = 6;
    localparam int BOM_CNT_W       = 4;
    localparam int BOM_MIN_REPS    = 10;
endpackage

// File: rtl/bom_seq.sv
// Module: bom_seq
// Purpose: tracks the position within the current codeword, latches the code
//          at the start of each codeword, and supplies the bit for every
//          bit_en that belongs to a codeword.
// Assumes: bit_en is a single-cycle qualifier per line bit; send is sampled on
//          bit_en cycles only when no codeword is in progress.
module bom_seq #(
    parameter int PREFIX_ONES = bom_pkg::BOM_PREFIX_ONES,
    parameter int CODE_W      = bom_pkg::BOM_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              send,
    input  logic [CODE_W-1:0] code,
    output logic              word_sel,
    output logic              word_bit,
    output logic              word_end
);
    localparam int WORD_LEN = PREFIX_ONES + CODE_W + 2;
    localparam int POS_W    = $clog2(WORD_LEN);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(WORD_LEN - 1);

    logic              busy;
    logic [POS_W-1:0]  pos;
    logic [CODE_W-1:0] code_l;
    logic [CODE_W-1:0] code_src;
    logic [WORD_LEN-1:0] word_vec;

    // Code source: live input on the starting bit, latched copy afterwards.
    assign code_src = busy ? code_l : code;

    // Build the codeword, one bit per position.
    for (genvar i = 0; i < WORD_LEN; i++) begin : g_word
        if (i < PREFIX_ONES) begin : g_one
            assign word_vec[i] = 1'b1;
        end else if (i == PREFIX_ONES || i == WORD_LEN - 1) begin : g_zero
            assign word_vec[i] = 1'b0;
        end else begin : g_code
            assign word_vec[i] = code_src[i-PREFIX_ONES-1];
        end
    end

    // Select the current codeword bit and the codeword status strobes.
    always_comb begin
        word_sel = busy | send;
        word_bit = busy ? word_vec[pos] : word_vec[0];
        word_end = bit_en & busy & (pos == LAST_POS);
    end

    // Advance the position, start new codewords and finish codewords.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            pos    <= '0;
            code_l <= '0;
        end else if (bit_en) begin
            if (!busy && send) begin
                busy   <= 1'b1;
                pos    <= POS_W'(1);
                code_l <= code;
            end else if (busy) begin
                if (pos == LAST_POS) begin
                    busy <= 1'b0;
                    pos  <= '0;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    AST_WORD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !busy && send) |=> busy); // R3
    AST_WORD_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && busy && pos != LAST_POS) |=> busy); // R5
    AST_POS_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && busy && pos != LAST_POS) |=> (pos == $past(pos) + 1'b1)); // R2
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_end) |=> $stable(code_l)); // R4
endmodule

// File: rtl/bom_out_mux.sv
// Module: bom_out_mux
// Purpose: registers the line bit, choosing the codeword bit, the
//          pass-through data or ones idle, updated only on bit_en.
// Assumes: word_sel and word_bit come from bom_seq in the same cycle.
module bom_out_mux (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic word_sel,
    input  logic word_bit,
    input  logic pass_sel,
    input  logic link_in,
    output logic dl_out
);
    // Output register: codeword bit, pass-through data or ones idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_out <= 1'b1;
        end else if (bit_en) begin
            if (word_sel) begin
                dl_out <= word_bit;
            end else begin
                dl_out <= pass_sel ? link_in : 1'b1;
            end
        end
    end

    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dl_out)); // R7
    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !word_sel && !pass_sel) |=> dl_out); // R6
endmodule

// File: rtl/bom_rep_cnt.sv
// Module: bom_rep_cnt
// Purpose: counts complete codewords sent while send is high, saturating,
//          and flags when the minimum repetition count is reached.
// Assumes: word_end pulses once per finished codeword; clearing on send low
//          has priority over counting.
module bom_rep_cnt #(
    parameter int CNT_W    = bom_pkg::BOM_CNT_W,
    parameter int MIN_REPS = bom_pkg::BOM_MIN_REPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic             word_end,
    output logic [CNT_W-1:0] rep_count,
    output logic             rep_done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_REPS);

    // Repetition counter: clear when idle, count finished words, saturate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_count <= '0;
        end else if (!send) begin
            rep_count <= '0;
        end else if (word_end && rep_count != CNT_MAX) begin
            rep_count <= rep_count + 1'b1;
        end
    end

    // Minimum-send flag.
    assign rep_done = (rep_count >= CNT_MIN);

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !send |=> (rep_count == '0)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (send && rep_count == CNT_MAX) |=> (rep_count == CNT_MAX)); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        send |=> (rep_count == $past(rep_count) || rep_count == $past(rep_count) + 1'b1)); // R8
endmodule

// File: rtl/bom_tx.sv
// Module: bom_tx
// Purpose: top of the bit-oriented message transmitter; joins the codeword
//          sequencer, the output register and the repetition counter.
// Assumes: one line bit per bit_en cycle; synchronous active-low reset.
module bom_tx #(
    parameter int PREFIX_ONES = bom_pkg::BOM_PREFIX_ONES,
    parameter int CODE_W      = bom_pkg::BOM_CODE_W,
    parameter int CNT_W       = bom_pkg::BOM_CNT_W,
    parameter int MIN_REPS    = bom_pkg::BOM_MIN_REPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              send,
    input  logic [CODE_W-1:0] code,
    input  logic              pass_sel,
    input  logic              link_in,
    output logic              dl_out,
    output logic [CNT_W-1:0]  rep_count,
    output logic              rep_done
);
    logic word_sel;
    logic word_bit;
    logic word_end;

    bom_seq #(
        .PREFIX_ONES (PREFIX_ONES),
        .CODE_W      (CODE_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .send     (send),
        .code     (code),
        .word_sel (word_sel),
        .word_bit (word_bit),
        .word_end (word_end)
    );

    bom_out_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .word_sel (word_sel),
        .word_bit (word_bit),
        .pass_sel (pass_sel),
        .link_in  (link_in),
        .dl_out   (dl_out)
    );

    bom_rep_cnt #(
        .CNT_W    (CNT_W),
        .MIN_REPS (MIN_REPS)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .send      (send),
        .word_end  (word_end),
        .rep_count (rep_count),
        .rep_done  (rep_done)
    );
endmodule

// File: tb/bom_tx_tb.sv
// Scoreboard bench: the driver task applies inputs at the falling edge and
// queues the expected outputs; the monitor compares them after the rising edge.
module bom_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bit_en, send, pass_sel, link_in;
    logic [5:0] code;
    logic       dl_out;
    logic [3:0] rep_count;
    logic       rep_done;

    int n_checks = 0;
    int n_fails  = 0;

    // reference model state, derived from the requirements
    bit       m_busy = 1'b0;
    int       m_pos  = 0;
    bit [5:0] m_code = '0;
    bit       m_out  = 1'b1;
    int       m_cnt  = 0;

    bit       q_dl[$];
    bit [3:0] q_cnt[$];
    bit       q_done[$];
    string    q_tag[$];

    always #10 clk = ~clk; // 50 MHz

    bom_tx u_dut (
        .clk (clk), .rst_n (rst_n), .bit_en (bit_en), .send (send),
        .code (code), .pass_sel (pass_sel), .link_in (link_in),
        .dl_out (dl_out), .rep_count (rep_count), .rep_done (rep_done)
    );

    function automatic bit exp_bit(int p, bit [5:0] c);
        if (p < 8)  return 1'b1;
        if (p == 8) return 1'b0;
        if (p < 15) return c[p-9];
        return 1'b0;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(bit be, bit sd, bit [5:0] cd, bit ps, bit li, string tag);
        bit wend;
        @(negedge clk);
        bit_en = be; send = sd; code = cd; pass_sel = ps; link_in = li;
        wend = 1'b0;
        if (be) begin
            if (m_busy || sd) begin
                if (!m_busy) begin
                    m_busy = 1'b1; m_pos = 0; m_code = cd;
                end
                m_out = exp_bit(m_pos, m_code);
                if (m_pos == 15) begin
                    wend = 1'b1; m_busy = 1'b0; m_pos = 0;
                end else begin
                    m_pos++;
                end
            end else begin
                m_out = ps ? li : 1'b1;
            end
        end
        if (!sd) m_cnt = 0;
        else if (wend && m_cnt < 15) m_cnt++;
        q_dl.push_back(m_out);
        q_cnt.push_back(4'(m_cnt));
        q_done.push_back(m_cnt >= 10);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare outputs with the queued expectation after each edge.
    always @(posedge clk) begin
        #5;
        if (q_dl.size() > 0) begin
            string t;
            bit    e_dl;
            bit [3:0] e_cnt;
            bit    e_done;
            t = q_tag.pop_front();
            e_dl = q_dl.pop_front();
            e_cnt = q_cnt.pop_front();
            e_done = q_done.pop_front();
            check(t, "dl_out", int'(dl_out), int'(e_dl));
            check(t, "rep_count", int'(rep_count), int'(e_cnt));
            check("R10", "rep_done", int'(rep_done), int'(e_done));
        end
    end

    initial begin
        #(20 * 100000);
        n_fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        rst_n = 1'b0; bit_en = 1'b1; send = 1'b1; code = 6'h2A;
        pass_sel = 1'b1; link_in = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state, even with a send request and enables present
        check("R1", "dl_out", int'(dl_out), 1);
        check("R1", "rep_count", int'(rep_count), 0);
        check("R1", "rep_done", int'(rep_done), 0);
        send = 1'b0;
        rst_n = 1'b1;

        // R6: ones idle ignores link_in
        for (int i = 0; i < 6; i++) step(1, 0, 6'h00, 0, i[0], "R6");
        // R6: pass-through follows link_in
        for (int i = 0; i < 8; i++) step(1, 0, 6'h00, 1, i[1] ^ i[0], "R6");
        // R7: no enable, output holds while link_in toggles
        for (int i = 0; i < 5; i++) step(0, 0, 6'h00, 1, i[0], "R7");

        // R2/R3: continuous codewords, enable every cycle
        for (int i = 0; i < 48; i++) step(1, 1, 6'b100101, 0, 1'b0, "R2");
        // R7/R3: sparse enable, codeword continues across held cycles
        for (int i = 0; i < 48; i++) step(i % 3 == 0, 1, 6'b100101, 0, 1'b0, "R3");
        // R4: code changes mid-word only affect later codewords
        for (int i = 0; i < 64; i++) step(1, 1, (i % 16 < 6) ? 6'b010011 : 6'b111000, 0, 1'b0, "R4");
        // R8/R10: run on to saturation
        for (int i = 0; i < 112; i++) step(1, 1, 6'b001110, 0, 1'b0, "R8");
        // R5/R9: send falls mid-word; the word completes, the counter clears
        for (int i = 0; i < 5; i++) step(1, 1, 6'b110110, 1, 1'b0, "R5");
        for (int i = 0; i < 20; i++) step(1, 0, 6'b000000, 1, i[0], "R5");

        // R9: send falls on the very bit that closes the second codeword
        for (int i = 0; i < 31; i++) step(1, 1, 6'b011001, 0, 1'b0, "R9");
        step(1, 0, 6'b011001, 0, 1'b0, "R9");
        for (int i = 0; i < 4; i++) step(1, 0, 6'b011001, 1, 1'b0, "R9");
        // R4: new code presented on the starting bit of a codeword
        for (int i = 0; i < 16; i++) step(1, 1, (i == 0) ? 6'b101011 : 6'b000000, 0, 1'b0, "R4");
        for (int i = 0; i < 4; i++) step(0, 0, 6'h00, 0, 1'b0, "R7");
        repeat (3) @(posedge clk);
        summary();
    end
endmodule